// File: doc/BRIEF.md
# Per-Warp Locality Classifier

This block watches a stream of cache outcomes, one per cycle at most, each tagged with the warp that issued the access and whether it hit. For every warp it keeps a hit count and an access count, and from those it places the warp into one of five locality classes: all-hit, mostly-hit, balanced, mostly-miss or all-miss. Neighbouring logic, such as a cache bypass decision, an insertion-position choice or a memory request prioriser, asks for a warp's class through a lookup port. The answer comes back combinationally in the same cycle.

The ratio hits/accesses is never divided out. The class boundaries are fractions with a common denominator, and each boundary is tested by comparing two products. Warps with too few accesses to judge are reported as balanced. A free-running interval timer wipes every warp's counts in one cycle so that profiling restarts and the classes can follow phase changes in the workload.

Top module: `warp_locality_classifier`

## Requirements
- R1: After reset, every warp reports class code 2 (balanced).
- R2: Each cycle with `ev_valid_i` high adds one access, plus one hit if `ev_hit_i` is 1, to the warp `ev_warp_i`. Cycles with `ev_valid_i` low change no warp's counts.
- R3: A warp whose access count is below `MIN_ACC` reports code 2 (balanced), whatever its hits.
- R4: A warp with at least `MIN_ACC` accesses and no misses reports code 0 (all-hit). One with at least `MIN_ACC` accesses and no hits reports code 4 (all-miss).
- R5: Otherwise the warp reports code 1 (mostly-hit) when hits*`RATIO_DEN` >= accesses*`HIT_HI_NUM`. The boundary itself counts as mostly-hit.
- R6: Otherwise the warp reports code 3 (mostly-miss) when hits*`RATIO_DEN` <= accesses*`HIT_LO_NUM`. The boundary itself counts as mostly-miss.
- R7: A warp with enough accesses that falls between the two thresholds, and has both hits and misses, reports code 2 (balanced).
- R8: Events for one warp never change the class of another warp.
- R9: Once a warp's access count reaches 2^`CNT_W`-1, later events for that warp are dropped until the next interval clear, so its ratio stays frozen.
- R10: On every `INTERVAL`-th clock edge after reset, all counts clear together. An event presented in that same cycle becomes the first access of the new interval.
- R11: `lk_class_o` follows `lk_warp_i` combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid_i | input | 1 | A cache outcome is present this cycle |
| ev_warp_i | input | $clog2(NUM_WARPS) | Warp that issued the access |
| ev_hit_i | input | 1 | 1 = hit, 0 = miss |
| lk_warp_i | input | $clog2(NUM_WARPS) | Warp whose class is requested |
| lk_class_o | output | 3 | Class: 0 all-hit, 1 mostly-hit, 2 balanced, 3 mostly-miss, 4 all-miss |

## Verification
A corrupted hit or access count appears at the lookup port on the very next cycle, but only when that warp is looked up and the error moves it across a class boundary. For that reason the directed scenarios place warps exactly on each threshold and one step beside it. A stuck or mistimed interval timer shows up as a class that survives a clear edge, or as an event lost on that edge. The bench therefore aligns one scenario so that an event falls on the clearing cycle itself. A missing saturation guard shows up only after the access counter wraps. The saturation scenario therefore drives more events into one warp than the counter can hold.

// File: rtl/wlc_pkg.sv
package wlc_pkg;
    typedef enum logic [2:0] {
        CLS_ALL_HIT     = 3'd0,
        CLS_MOSTLY_HIT  = 3'd1,
        CLS_BALANCED    = 3'd2,
        CLS_MOSTLY_MISS = 3'd3,
        CLS_ALL_MISS    = 3'd4
    } loc_class_e;
endpackage

// File: rtl/wlc_interval_timer.sv
module wlc_interval_timer #(
    parameter int INTERVAL = 4096
) (
    input  logic clk,
    input  logic rst_n,
    output logic epoch_end_o
);
    localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        epoch_end_o = (st_q.cnt == LAST);
        if (epoch_end_o) st_d.cnt = '0;
        else             st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST); // R10
    AST_TIMER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        epoch_end_o |=> (st_q.cnt == '0)); // R10
endmodule

// File: rtl/wlc_counter_bank.sv
module wlc_counter_bank #(
    parameter int NUM_WARPS = 32,
    parameter int CNT_W     = 8,
    localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             ev_valid_i,
    input  logic [WID_W-1:0] ev_warp_i,
    input  logic             ev_hit_i,
    input  logic [WID_W-1:0] rd_warp_i,
    output logic [CNT_W-1:0] rd_hits_o,
    output logic [CNT_W-1:0] rd_acc_o
);
    localparam logic [CNT_W-1:0] ACC_MAX = '1;

    typedef struct packed {
        logic [NUM_WARPS-1:0][CNT_W-1:0] hits;
        logic [NUM_WARPS-1:0][CNT_W-1:0] acc;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.hits = '0;
            st_d.acc  = '0;
        end
        if (ev_valid_i && (st_d.acc[ev_warp_i] != ACC_MAX)) begin
            st_d.acc[ev_warp_i] = st_d.acc[ev_warp_i] + 1'b1;
            if (ev_hit_i) st_d.hits[ev_warp_i] = st_d.hits[ev_warp_i] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_hits_o = st_q.hits[rd_warp_i];
    assign rd_acc_o  = st_q.acc[rd_warp_i];

    for (genvar gi = 0; gi < NUM_WARPS; gi++) begin : g_chk
        AST_HITS_LE_ACC: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.hits[gi] <= st_q.acc[gi]); // R2
        AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.acc[gi] == ACC_MAX && !clear_i) |=> (st_q.acc[gi] == ACC_MAX)); // R9
        AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
            clear_i |=> (st_q.acc[gi] <= CNT_W'(1))); // R10
        AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!ev_valid_i && !clear_i) |=> $stable(st_q.acc[gi])); // R2
    end
endmodule

// File: rtl/wlc_class_decider.sv
module wlc_class_decider
    import wlc_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int MIN_ACC    = 8,
    parameter int RATIO_DEN  = 8,
    parameter int HIT_HI_NUM = 6,
    parameter int HIT_LO_NUM = 2
) (
    input  logic [CNT_W-1:0] hits_i,
    input  logic [CNT_W-1:0] acc_i,
    output loc_class_e       class_o
);
    localparam int PROD_W = CNT_W + $clog2(RATIO_DEN + 1);
    localparam logic [PROD_W-1:0] DEN_P = PROD_W'(RATIO_DEN);
    localparam logic [PROD_W-1:0] HI_P  = PROD_W'(HIT_HI_NUM);
    localparam logic [PROD_W-1:0] LO_P  = PROD_W'(HIT_LO_NUM);
    localparam logic [CNT_W-1:0]  MIN_V = CNT_W'(MIN_ACC);

    logic [PROD_W-1:0] hit_scaled;
    logic [PROD_W-1:0] hi_bound;
    logic [PROD_W-1:0] lo_bound;

    always_comb begin
        hit_scaled = PROD_W'(hits_i) * DEN_P;
        hi_bound   = PROD_W'(acc_i) * HI_P;
        lo_bound   = PROD_W'(acc_i) * LO_P;
        class_o    = CLS_BALANCED;
        if (acc_i >= MIN_V) begin
            if (hits_i == acc_i)            class_o = CLS_ALL_HIT;
            else if (hits_i == '0)          class_o = CLS_ALL_MISS;
            else if (hit_scaled >= hi_bound) class_o = CLS_MOSTLY_HIT;
            else if (hit_scaled <= lo_bound) class_o = CLS_MOSTLY_MISS;
        end
    end
endmodule

// File: rtl/warp_locality_classifier.sv
module warp_locality_classifier
    import wlc_pkg::*;
#(
    parameter int NUM_WARPS  = 32,
    parameter int CNT_W      = 8,
    parameter int MIN_ACC    = 8,
    parameter int INTERVAL   = 4096,
    parameter int RATIO_DEN  = 8,
    parameter int HIT_HI_NUM = 6,
    parameter int HIT_LO_NUM = 2,
    localparam int WID_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid_i,
    input  logic [WID_W-1:0] ev_warp_i,
    input  logic             ev_hit_i,
    input  logic [WID_W-1:0] lk_warp_i,
    output logic [2:0]       lk_class_o
);
    logic             epoch_end;
    logic [CNT_W-1:0] rd_hits;
    logic [CNT_W-1:0] rd_acc;
    loc_class_e       cls;

    wlc_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .epoch_end_o (epoch_end)
    );

    wlc_counter_bank #(.NUM_WARPS(NUM_WARPS), .CNT_W(CNT_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (epoch_end),
        .ev_valid_i (ev_valid_i),
        .ev_warp_i  (ev_warp_i),
        .ev_hit_i   (ev_hit_i),
        .rd_warp_i  (lk_warp_i),
        .rd_hits_o  (rd_hits),
        .rd_acc_o   (rd_acc)
    );

    wlc_class_decider #(
        .CNT_W      (CNT_W),
        .MIN_ACC    (MIN_ACC),
        .RATIO_DEN  (RATIO_DEN),
        .HIT_HI_NUM (HIT_HI_NUM),
        .HIT_LO_NUM (HIT_LO_NUM)
    ) u_decide (
        .hits_i  (rd_hits),
        .acc_i   (rd_acc),
        .class_o (cls)
    );

    assign lk_class_o = cls;

    AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        lk_class_o <= 3'd4); // R7
    AST_FEW_ACC_BAL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc < CNT_W'(MIN_ACC)) |-> (lk_class_o == 3'd2)); // R3
    AST_ALL_HIT_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_class_o == 3'd0) |-> (rd_hits == rd_acc)); // R4
    AST_ALL_MISS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_class_o == 3'd4) |-> (rd_hits == '0)); // R4
endmodule

// File: tb/tb_warp_locality_classifier.sv
module tb_warp_locality_classifier;
    localparam int NW  = 8;
    localparam int CW  = 4;
    localparam int MIN = 4;
    localparam int IVL = 128;
    localparam int WW  = $clog2(NW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_valid_i = 1'b0;
    logic [WW-1:0] ev_warp_i = '0;
    logic          ev_hit_i = 1'b0;
    logic [WW-1:0] lk_warp_i = '0;
    logic [2:0]    lk_class_o;

    int checks = 0;
    int errors = 0;
    int ecnt = 0;

    always #5 clk = ~clk;

    always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

    warp_locality_classifier #(
        .NUM_WARPS(NW), .CNT_W(CW), .MIN_ACC(MIN), .INTERVAL(IVL),
        .RATIO_DEN(8), .HIT_HI_NUM(6), .HIT_LO_NUM(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ev_valid_i(ev_valid_i), .ev_warp_i(ev_warp_i),
        .ev_hit_i(ev_hit_i), .lk_warp_i(lk_warp_i), .lk_class_o(lk_class_o)
    );

    task automatic chk(input int w, input logic [2:0] exp, input string req);
        lk_warp_i = WW'(w);
        #1;
        checks++;
        if (lk_class_o !== exp) begin
            errors++;
            $display("FAIL %s warp %0d: actual %0d expected %0d", req, w, lk_class_o, exp);
        end
    endtask

    // Drive one event at the current negedge, return at the next negedge.
    task automatic put(input int w, input bit h);
        ev_valid_i = 1'b1; ev_warp_i = WW'(w); ev_hit_i = h;
        @(negedge clk);
        ev_valid_i = 1'b0;
    endtask

    task automatic burst(input int w, input int nh, input int nm);
        for (int i = 0; i < nh; i++) put(w, 1'b1);
        for (int i = 0; i < nm; i++) put(w, 1'b0);
    endtask

    // Return at a negedge right after a clearing edge.
    task automatic align();
        do @(negedge clk); while (ecnt % IVL != 0);
    endtask

    task automatic t_reset();
        for (int w = 0; w < NW; w++) chk(w, 3'd2, "R1");
    endtask

    task automatic t_min_and_pure();
        align();
        burst(1, 3, 0);
        chk(1, 3'd2, "R3");
        put(1, 1'b1);
        chk(1, 3'd0, "R4 all-hit");
        burst(2, 0, 4);
        chk(2, 3'd4, "R4 all-miss");
    endtask

    task automatic t_thresholds();
        align();
        burst(1, 3, 1);
        chk(1, 3'd1, "R5 boundary");
        burst(2, 1, 3);
        chk(2, 3'd3, "R6 boundary");
        burst(3, 2, 2);
        chk(3, 3'd2, "R7");
        burst(4, 5, 3);
        chk(4, 3'd2, "R7 just below hi");
        burst(5, 2, 6);
        chk(5, 3'd3, "R6 2/8");
        burst(6, 3, 6);
        chk(6, 3'd2, "R7 just above lo");
        burst(7, 7, 1);
        chk(7, 3'd1, "R5 7/8");
    endtask

    task automatic t_idle_and_isolation();
        align();
        burst(3, 0, 4);
        chk(3, 3'd4, "R8 setup");
        burst(5, 4, 0);
        chk(3, 3'd4, "R8 other warp");
        chk(5, 3'd0, "R8");
        // Drive warp 3 hits with valid low: must not count.
        ev_warp_i = WW'(3); ev_hit_i = 1'b1;
        repeat (10) @(negedge clk);
        chk(3, 3'd4, "R2 valid low");
        put(3, 1'b1);
        chk(3, 3'd3, "R2 counted 1/5");
    endtask

    task automatic t_lookup_comb();
        align();
        burst(0, 4, 0);
        burst(6, 0, 4);
        lk_warp_i = WW'(0); #1;
        lk_warp_i = WW'(6); #1;
        checks++;
        if (lk_class_o !== 3'd4) begin
            errors++;
            $display("FAIL R11 actual %0d expected 4", lk_class_o);
        end
        lk_warp_i = WW'(0); #1;
        checks++;
        if (lk_class_o !== 3'd0) begin
            errors++;
            $display("FAIL R11 actual %0d expected 0", lk_class_o);
        end
    endtask

    task automatic t_saturate();
        align();
        burst(2, 15, 10);
        chk(2, 3'd0, "R9 frozen");
        burst(4, 0, 20);
        put(4, 1'b1);
        chk(4, 3'd4, "R9 frozen miss");
    endtask

    task automatic t_interval();
        align();
        burst(1, 0, 4);
        burst(2, 4, 0);
        chk(1, 3'd4, "R10 before");
        do @(negedge clk); while (ecnt % IVL != IVL - 1);
        put(1, 1'b1);              // lands on the clearing edge
        chk(1, 3'd2, "R10 one access");
        chk(2, 3'd2, "R10 cleared");
        burst(1, 3, 0);
        chk(1, 3'd0, "R10 event kept");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_min_and_pure();
        t_thresholds();
        t_idle_and_isolation();
        t_lookup_comb();
        t_saturate();
        t_interval();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule